// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one parallel character into an asynchronous serial frame on a single output line. The frame shape comes from a small set of line-control inputs: the character length (5 to 8 data bits), whether a parity bit is added, whether that parity is even or odd, and how long the stop period is (one, one-and-a-half or two bit times). Bit timing is counted in pulses of a 16x oversampling tick supplied from outside, so half-bit stop periods come out exact.

A producer offers a byte with a valid/ready handshake. The byte and the line-control inputs are captured together on the accepting cycle. They then stay fixed for the whole frame, whatever the inputs do meanwhile. The controller is a five-state machine:
- `TX_IDLE` waits for a byte. It moves to `TX_START` on acceptance.
- `TX_START` drives the low start bit. It moves to `TX_DATA` after 16 ticks.
- `TX_DATA` sends the data bits LSB first, 16 ticks each. After the last active bit it moves to `TX_PARITY` if parity is enabled, or to `TX_STOP` if it is not.
- `TX_PARITY` sends the parity bit for 16 ticks. It then moves to `TX_STOP`.
- `TX_STOP` holds the line high for 16, 24 or 32 ticks. It then returns to `TX_IDLE`.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line is high, `in_ready` is high and `busy` is low. The line-control state behaves as 5 data bits, one stop bit, no parity.
- R2: `in_ready` is high only while the transmitter is idle. A byte is taken on a rising clock edge where `in_valid` and `in_ready` are both high. Any `in_valid` or `in_data` activity while busy has no effect on the frame in progress.
- R3: The first clock after acceptance begins the start bit. The start bit holds the line low for exactly 16 tick pulses.
- R4: `lcr_len` selects the data-bit count: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. The bits go out LSB first (`in_data[0]` first), each for 16 tick pulses. Bits above the selected length are never sent.
- R5: With `lcr_parity_en` = 0, no parity bit is sent and the stop period follows the last data bit directly. With `lcr_parity_en` = 1, one parity bit of 16 ticks follows the data.
- R6: The parity bit is the XOR of the active data bits only. It is inverted when `parity_odd` = 1 (odd parity) and left as is when `parity_odd` = 0 (even parity).
- R7: With `lcr_two_stop` = 0, the line is high for exactly 16 tick pulses of stop period.
- R8: With `lcr_two_stop` = 1, the stop period lasts 32 tick pulses. When `lcr_len` = 00, it lasts 24 tick pulses instead.
- R9: Line-control inputs and `parity_odd` are captured at acceptance. Changes to them during a frame have no effect on that frame.
- R10: `busy` is high from the cycle after acceptance until the stop period ends. Clock cycles without a tick pulse never advance the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send, bit 0 first |
| in_ready | output | 1 | Transmitter idle and able to take a byte |
| lcr_len | input | 2 | Data length select (00=5 ... 11=8) |
| lcr_two_stop | input | 1 | Long stop period select |
| lcr_parity_en | input | 1 | Parity bit enable |
| parity_odd | input | 1 | Odd parity select (0 = even) |
| tx_line | output | 1 | Serial output, idles high |
| busy | output | 1 | Frame in progress |

## Verification
A wrong state or counter inside this block shows at `tx_line` as a level change that arrives too early or too late. The bench's reference model predicts the line level on every clock. A bit-timer slip is therefore caught at the first tick pulse where the boundary should have fallen, within one bit time. A wrong data index or parity value makes a wrong line level for the whole of that bit. A wrong stop length or a broken return to idle shows up on `in_ready` and `busy` in the cycle after the stop period should have ended.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int TX_DW     = 8;
    localparam int TX_OSR    = 16;
    localparam int TX_TICK_W = $clog2(2 * TX_OSR);
    localparam int TX_NB_W   = $clog2(TX_DW + 1);
    localparam int TX_MIN_NB = TX_DW - 3;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP
    } tx_state_t;

    typedef struct packed {
        logic [TX_NB_W-1:0]   nbits;
        logic                 par_en;
        logic [TX_TICK_W-1:0] stop_lim;
    } tx_fmt_t;

endpackage

// File: rtl/uart_tx_fmt_reg.sv
module uart_tx_fmt_reg
    import uart_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] len_sel,
    input  logic       two_stop,
    input  logic       par_en,
    output tx_fmt_t    fmt_q
);

    localparam logic [TX_TICK_W-1:0] LIM_ONE  = TX_TICK_W'(TX_OSR - 1);
    localparam logic [TX_TICK_W-1:0] LIM_HALF = TX_TICK_W'(TX_OSR + TX_OSR / 2 - 1);
    localparam logic [TX_TICK_W-1:0] LIM_TWO  = TX_TICK_W'(2 * TX_OSR - 1);

    tx_fmt_t fmt_d;

    always_comb begin
        fmt_d.nbits  = TX_NB_W'(TX_MIN_NB) + TX_NB_W'(len_sel);
        fmt_d.par_en = par_en;
        if (!two_stop)
            fmt_d.stop_lim = LIM_ONE;
        else if (len_sel == 2'b00)
            fmt_d.stop_lim = LIM_HALF;
        else
            fmt_d.stop_lim = LIM_TWO;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_q.nbits    <= TX_NB_W'(TX_MIN_NB);
            fmt_q.par_en   <= 1'b0;
            fmt_q.stop_lim <= LIM_ONE;
        end else if (load) begin
            fmt_q <= fmt_d;
        end
    end

    // R4: captured length always stays within the legal range
    a_r4_nbits_range: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_q.nbits >= TX_NB_W'(TX_MIN_NB)) && (fmt_q.nbits <= TX_NB_W'(TX_DW)));

endmodule

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer
    import uart_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 tick,
    input  logic [TX_TICK_W-1:0] limit,
    output logic                 done
);

    logic [TX_TICK_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= (cnt_q == limit) ? '0 : cnt_q + 1'b1;
    end

    always_comb done = tick && !clear && (cnt_q == limit);

    // R8: tick count never runs past the current period limit
    a_r8_cnt_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |-> (cnt_q <= limit));

    // R10: without a tick pulse the count does not move
    a_r10_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> $stable(cnt_q));

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [TX_DW-1:0]   data,
    input  logic [TX_NB_W-1:0] nbits,
    input  logic               odd,
    input  logic               shift,
    output logic               ser_bit,
    output logic               par_bit
);

    logic [TX_DW-1:0] mask;
    logic [TX_DW-1:0] sh_q;
    logic             par_q;

    for (genvar i = 0; i < TX_DW; i++) begin : g_mask
        assign mask[i] = (TX_NB_W'(i) < nbits);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            par_q <= 1'b0;
        end else if (load) begin
            sh_q  <= data;
            par_q <= (^(data & mask)) ^ odd;
        end else if (shift) begin
            sh_q  <= sh_q >> 1;
        end
    end

    always_comb begin
        ser_bit = sh_q[0];
        par_bit = par_q;
    end

    // R6: parity value is frozen between loads
    a_r6_parity_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(par_q));

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick16,
    input  logic             in_valid,
    input  logic [TX_DW-1:0] in_data,
    output logic             in_ready,
    input  logic [1:0]       lcr_len,
    input  logic             lcr_two_stop,
    input  logic             lcr_parity_en,
    input  logic             parity_odd,
    output logic             tx_line,
    output logic             busy
);

    localparam logic [TX_TICK_W-1:0] BIT_LIM = TX_TICK_W'(TX_OSR - 1);

    tx_state_t            state_q, state_d;
    tx_fmt_t              fmt_q;
    logic [TX_NB_W-1:0]   bit_idx_q;
    logic                 accept;
    logic                 done;
    logic                 last_bit;
    logic                 ser_bit, par_bit;
    logic [TX_TICK_W-1:0] limit;

    always_comb accept = in_valid && in_ready;

    uart_tx_fmt_reg u_fmt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .len_sel  (lcr_len),
        .two_stop (lcr_two_stop),
        .par_en   (lcr_parity_en),
        .fmt_q    (fmt_q)
    );

    always_comb limit = (state_q == TX_STOP) ? fmt_q.stop_lim : BIT_LIM;

    uart_tx_bit_timer u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q == TX_IDLE),
        .tick  (tick16),
        .limit (limit),
        .done  (done)
    );

    uart_tx_shifter u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .data    (in_data),
        .nbits   (TX_NB_W'(TX_MIN_NB) + TX_NB_W'(lcr_len)),
        .odd     (parity_odd),
        .shift   ((state_q == TX_DATA) && done),
        .ser_bit (ser_bit),
        .par_bit (par_bit)
    );

    always_comb last_bit = (bit_idx_q == fmt_q.nbits - 1'b1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= TX_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bit_idx_q <= '0;
        else if (state_q != TX_DATA)
            bit_idx_q <= '0;
        else if (done)
            bit_idx_q <= bit_idx_q + 1'b1;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:   if (accept) state_d = TX_START;
            TX_START:  if (done)   state_d = TX_DATA;
            TX_DATA:   if (done && last_bit)
                           state_d = fmt_q.par_en ? TX_PARITY : TX_STOP;
            TX_PARITY: if (done)   state_d = TX_STOP;
            TX_STOP:   if (done)   state_d = TX_IDLE;
            default:               state_d = TX_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        tx_line  = 1'b1;
        busy     = 1'b1;
        in_ready = 1'b0;
        unique case (state_q)
            TX_IDLE:   begin busy = 1'b0; in_ready = 1'b1; end
            TX_START:  tx_line = 1'b0;
            TX_DATA:   tx_line = ser_bit;
            TX_PARITY: tx_line = par_bit;
            TX_STOP:   tx_line = 1'b1;
            default:   begin busy = 1'b0; in_ready = 1'b1; end
        endcase
    end

    // R2: an accepted byte begins its frame on the next cycle
    a_r2_accept_to_start: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (state_q == TX_START));

    // R3: a frame always opens with the line low
    a_r3_rise_busy_low_line: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !tx_line);

    // R4: data index stays within the captured length
    a_r4_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_DATA) |-> (bit_idx_q < fmt_q.nbits));

    // R9: captured format is constant during a frame
    a_r9_fmt_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(fmt_q));

    // R10: frame ends only from the stop period
    a_r10_end_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(state_q) == TX_STOP));

endmodule

// File: tb/uart_frame_tx_tb_top.sv
module uart_frame_tx_tb_top;
    import uart_tx_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick16 = 1'b0;
    logic             in_valid = 1'b0;
    logic [TX_DW-1:0] in_data = '0;
    logic [1:0]       lcr_len = 2'b00;
    logic             lcr_two_stop = 1'b0;
    logic             lcr_parity_en = 1'b0;
    logic             parity_odd = 1'b0;
    logic             in_ready, tx_line, busy;

    always #5 clk = ~clk;

    uart_frame_tx dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick16        (tick16),
        .in_valid      (in_valid),
        .in_data       (in_data),
        .in_ready      (in_ready),
        .lcr_len       (lcr_len),
        .lcr_two_stop  (lcr_two_stop),
        .lcr_parity_en (lcr_parity_en),
        .parity_odd    (parity_odd),
        .tx_line       (tx_line),
        .busy          (busy)
    );

    typedef struct {
        bit    level;
        int    ticks;
        string tag;
    } seg_t;

    seg_t  segq[$];
    seg_t  cur;
    bit    m_active = 0;
    int    rem = 0;
    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    int    tick_div = 1;
    int    tick_ph = 0;
    string phase = "R1";
    bit    finished = 0;

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s [%s] %s: actual %0b expected %0b at cycle %0d",
                     req, phase, what, act, exp, cyc);
        end
    endtask

    task automatic summary();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // tick pulse generator
    always @(negedge clk) begin
        if (tick_ph >= tick_div - 1) begin
            tick16  <= 1'b1;
            tick_ph <= 0;
        end else begin
            tick16  <= 1'b0;
            tick_ph <= tick_ph + 1;
        end
    end

    // behavioural reference model: list of line segments counted in ticks
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_active = 0;
            segq.delete();
        end else if (m_active) begin
            if (tick16) begin
                rem--;
                if (rem == 0) begin
                    if (segq.size() > 0) begin
                        cur = segq.pop_front();
                        rem = cur.ticks;
                    end else begin
                        m_active = 0;
                    end
                end
            end
        end else if (in_valid) begin
            int  nb;
            bit  p;
            nb = 5 + int'(lcr_len);
            segq.push_back('{1'b0, 16, "R3"});
            for (int i = 0; i < nb; i++)
                segq.push_back('{in_data[i], 16, "R4"});
            if (lcr_parity_en) begin
                p = parity_odd;
                for (int i = 0; i < nb; i++) p ^= in_data[i];
                segq.push_back('{p, 16, "R6"});
            end
            if (!lcr_two_stop)
                segq.push_back('{1'b1, 16, "R7"});
            else
                segq.push_back('{1'b1, (lcr_len == 2'b00) ? 24 : 32, "R8"});
            cur = segq.pop_front();
            rem = cur.ticks;
            m_active = 1;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(m_active ? cur.tag : "R5", tx_line, m_active ? cur.level : 1'b1, "tx_line");
            chk("R2", in_ready, !m_active, "in_ready");
            chk("R10", busy, m_active, "busy");
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (!finished && cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    task automatic send(input logic [7:0] d, input logic [1:0] len, input logic two,
                        input logic pen, input logic odd, input int hold, input bit perturb);
        while (!in_ready) @(negedge clk);
        in_data       = d;
        lcr_len       = len;
        lcr_two_stop  = two;
        lcr_parity_en = pen;
        parity_odd    = odd;
        in_valid      = 1'b1;
        @(negedge clk);
        // R2: valid kept high with changing data while busy
        for (int k = 0; k < hold; k++) begin
            in_data = ~in_data;
            @(negedge clk);
        end
        in_valid = 1'b0;
        if (perturb) begin
            // R9: change every format input mid-frame
            lcr_len       = ~len;
            lcr_two_stop  = ~two;
            lcr_parity_en = ~pen;
            parity_odd    = ~odd;
            in_data       = ~d;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", tx_line, 1'b1, "reset line");
        chk("R1", in_ready, 1'b1, "reset ready");
        chk("R1", busy, 1'b0, "reset busy");

        // R1: default format with inputs left at reset values
        phase = "R1 default format";
        send(8'h3A, 2'b00, 1'b0, 1'b0, 1'b0, 0, 0);

        // R4 R5 R7 R8: all lengths, stop lengths, parity on and off
        phase = "R4 R5 R7 R8 format sweep";
        for (int len = 0; len < 4; len++)
            for (int two = 0; two < 2; two++)
                for (int pen = 0; pen < 2; pen++) begin
                    tick_div = 1 + ((len + two) % 3);
                    send(8'hA5 ^ 8'(len * 37 + two * 11 + pen), 2'(len), 1'(two), 1'(pen), 1'b0, 0, 0);
                end

        // R6: odd and even parity, upper bits outside the length excluded
        phase = "R6 parity";
        tick_div = 1;
        send(8'hE0, 2'b00, 1'b0, 1'b1, 1'b0, 0, 0);
        send(8'hE0, 2'b00, 1'b0, 1'b1, 1'b1, 0, 0);
        send(8'hFF, 2'b11, 1'b1, 1'b1, 1'b1, 0, 0);
        send(8'h7F, 2'b10, 1'b0, 1'b1, 1'b1, 0, 0);
        send(8'h00, 2'b01, 1'b1, 1'b1, 1'b0, 0, 0);

        // R2: valid held while busy has no effect
        phase = "R2 valid while busy";
        send(8'h96, 2'b00, 1'b0, 1'b0, 1'b0, 50, 0);
        send(8'h5C, 2'b11, 1'b1, 1'b1, 1'b1, 60, 0);

        // R9: format inputs changed mid-frame
        phase = "R9 mid-frame change";
        send(8'hC3, 2'b00, 1'b1, 1'b0, 1'b0, 0, 1);
        send(8'h1E, 2'b11, 1'b0, 1'b1, 1'b1, 0, 1);

        // R10: sparse ticks stretch the frame
        phase = "R10 sparse ticks";
        tick_div = 4;
        send(8'h69, 2'b01, 1'b1, 1'b1, 1'b0, 0, 0);

        // R2: back-to-back frames with valid held through
        phase = "R2 back-to-back";
        tick_div = 1;
        while (!in_ready) @(negedge clk);
        in_data = 8'h81; lcr_len = 2'b00; lcr_two_stop = 1'b0; lcr_parity_en = 1'b0;
        in_valid = 1'b1;
        @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);

        summary();
    end

endmodule